// File: doc/BRIEF.md
# Message Object Interrupt Info Encoder

This block summarises the interrupt state of a bank of 32 message objects in two read-only byte registers. Each object contributes a message-complete flag, an interrupt-enable bit and three error event strobes: transmit buffer underflow, fragmentation error and receive buffer full. The completion summary tells software whether any enabled object has finished, and which one has the smallest number. An interrupt handler can service objects in index order by reading this single byte.

The error summary keeps only the latest message error. It stores a one-hot code for the error kind and the number of the object that raised it. A newer event overwrites the stored one, and cycles with no event leave it unchanged. Both summaries are registered. A small read port returns either byte alone, in the low half of the data with a zero high half, or both bytes together as one 16-bit word.

Top module: `msg_irq_info`

## Requirements
- R1: Bit 5 of the completion byte is 1 exactly when, on the previous clock, at least one object had both its complete flag and its enable bit set.
- R2: Bits 4:0 of the completion byte hold the smallest object index whose complete flag and enable bit were both set on the previous clock.
- R3: When no object was both complete and enabled on the previous clock, the completion byte reads 00h.
- R4: Bits 7:6 of the completion byte always read 0.
- R5: When an error event is present, the error byte on the next clock holds the kind in bits 7:5 and the object index in bits 4:0. The kind codes are 001 for receive buffer full, 010 for fragmentation and 100 for transmit underflow.
- R6: In a cycle with no error event on any object, the error byte keeps its value, so only the latest error is retained.
- R7: When several objects raise errors in the same cycle, the lowest-numbered object is the one recorded.
- R8: When one object raises several error kinds in the same cycle, the kind recorded is underflow if present, otherwise fragmentation, otherwise buffer full.
- R9: While reset is asserted, both bytes read 00h.
- R10: With rd_word=1, rd_data is {error byte, completion byte}. With rd_word=0, rd_data[7:0] holds the completion byte for rd_addr=0 or the error byte for rd_addr=1, and rd_data[15:8] is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmpl_flags | input | 32 | Message-complete flag per object |
| irq_en | input | 32 | Interrupt enable per object |
| ev_txund | input | 32 | Transmit buffer underflow strobe per object |
| ev_frag | input | 32 | Fragmentation error strobe per object |
| ev_rxfull | input | 32 | Receive buffer full strobe per object |
| rd_word | input | 1 | 1 selects a 16-bit read of both bytes |
| rd_addr | input | 1 | Byte select for byte reads: 0 completion, 1 error |
| rd_data | output | 16 | Read data |

## Verification
The hardest cases to reach from the ports are collisions in the error path: several objects raising errors in the same cycle, and one object raising two or three error kinds at once. Random strobes seldom hit either case in a controlled way, so directed steps drive them explicitly. Each step follows a cycle with a different stored value, so an overwrite is visible in the read data. The masked encoder gets table vectors where the flags and enables do not overlap, or overlap only above a low-order flag that is disabled. Random flag and enable pairs are then checked against a lowest-set-bit reference written in the bench.

// File: rtl/msg_irq_pkg.sv
package msg_irq_pkg;
  localparam int MAX_OBJ   = 32;
  localparam int REG_IDX_W = 5;
  localparam int BYTE_W    = 8;

  typedef enum logic [2:0] {
    EK_NONE   = 3'b000,
    EK_RXFULL = 3'b001,
    EK_FRAG   = 3'b010,
    EK_TXUND  = 3'b100
  } err_kind_e;

  // Lowest set position of a vector; 0 when empty.
  function automatic logic [REG_IDX_W-1:0] lowest_set(input logic [MAX_OBJ-1:0] v);
    logic [REG_IDX_W-1:0] r;
    r = '0;
    for (int i = MAX_OBJ - 1; i >= 0; i--) begin
      if (v[i]) r = REG_IDX_W'(i);
    end
    return r;
  endfunction

  // Priority among the kinds of one object: underflow, fragmentation, full.
  function automatic err_kind_e pick_kind(input logic und, input logic frg, input logic full);
    if (und)       return EK_TXUND;
    else if (frg)  return EK_FRAG;
    else if (full) return EK_RXFULL;
    else           return EK_NONE;
  endfunction

  function automatic logic [BYTE_W-1:0] pack_cmpl(input logic any, input logic [REG_IDX_W-1:0] idx);
    return {2'b00, any, idx};
  endfunction

  function automatic logic [BYTE_W-1:0] pack_err(input err_kind_e k, input logic [REG_IDX_W-1:0] idx);
    return {k, idx};
  endfunction
endpackage

// File: rtl/cmpl_encoder.sv
module cmpl_encoder
  import msg_irq_pkg::*;
#(
  parameter int NUM_OBJ = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_OBJ-1:0]   flags,
  input  logic [NUM_OBJ-1:0]   en,
  output logic [NUM_OBJ-1:0]   masked,
  output logic                 any_q,
  output logic [REG_IDX_W-1:0] idx_q
);
  logic                 any_d;
  logic [REG_IDX_W-1:0] idx_d;

  assign masked = flags & en;
  assign any_d  = |masked;
  assign idx_d  = lowest_set(MAX_OBJ'(masked));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      any_q <= 1'b0;
      idx_q <= '0;
    end else begin
      any_q <= any_d;
      idx_q <= any_d ? idx_d : '0;
    end
  end
endmodule

// File: rtl/err_capture.sv
module err_capture
  import msg_irq_pkg::*;
#(
  parameter int NUM_OBJ = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_OBJ-1:0]   txund,
  input  logic [NUM_OBJ-1:0]   frag,
  input  logic [NUM_OBJ-1:0]   rxfull,
  output logic                 evt,
  output err_kind_e            kind_q,
  output logic [REG_IDX_W-1:0] idx_q
);
  logic [NUM_OBJ-1:0]   obj_hit;
  logic [REG_IDX_W-1:0] win_idx;
  err_kind_e            win_kind;

  for (genvar g = 0; g < NUM_OBJ; g++) begin : g_hit
    assign obj_hit[g] = txund[g] | frag[g] | rxfull[g];
  end

  assign evt      = |obj_hit;
  assign win_idx  = lowest_set(MAX_OBJ'(obj_hit));
  assign win_kind = pick_kind(txund[win_idx], frag[win_idx], rxfull[win_idx]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q <= EK_NONE;
      idx_q  <= '0;
    end else if (evt) begin
      kind_q <= win_kind;
      idx_q  <= win_idx;
    end
  end
endmodule

// File: rtl/info_read_mux.sv
module info_read_mux
  import msg_irq_pkg::*;
(
  input  logic              rd_word,
  input  logic              rd_addr,
  input  logic [BYTE_W-1:0] cmpl_byte,
  input  logic [BYTE_W-1:0] err_byte,
  output logic [2*BYTE_W-1:0] rd_data
);
  always_comb begin
    if (rd_word)      rd_data = {err_byte, cmpl_byte};
    else if (rd_addr) rd_data = {{BYTE_W{1'b0}}, err_byte};
    else              rd_data = {{BYTE_W{1'b0}}, cmpl_byte};
  end
endmodule

// File: rtl/msg_irq_info.sv
module msg_irq_info
  import msg_irq_pkg::*;
#(
  parameter int NUM_OBJ = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_OBJ-1:0] cmpl_flags,
  input  logic [NUM_OBJ-1:0] irq_en,
  input  logic [NUM_OBJ-1:0] ev_txund,
  input  logic [NUM_OBJ-1:0] ev_frag,
  input  logic [NUM_OBJ-1:0] ev_rxfull,
  input  logic               rd_word,
  input  logic               rd_addr,
  output logic [15:0]        rd_data
);
  logic [NUM_OBJ-1:0]   cmpl_masked;
  logic                 cmpl_any_q;
  logic [REG_IDX_W-1:0] cmpl_idx_q;
  logic                 err_evt;
  err_kind_e            err_kind_q;
  logic [REG_IDX_W-1:0] err_idx_q;
  logic [BYTE_W-1:0]    cmpl_byte;
  logic [BYTE_W-1:0]    err_byte;

  cmpl_encoder #(.NUM_OBJ(NUM_OBJ)) u_cmpl (
    .clk(clk), .rst_n(rst_n), .flags(cmpl_flags), .en(irq_en),
    .masked(cmpl_masked), .any_q(cmpl_any_q), .idx_q(cmpl_idx_q)
  );

  err_capture #(.NUM_OBJ(NUM_OBJ)) u_err (
    .clk(clk), .rst_n(rst_n), .txund(ev_txund), .frag(ev_frag), .rxfull(ev_rxfull),
    .evt(err_evt), .kind_q(err_kind_q), .idx_q(err_idx_q)
  );

  assign cmpl_byte = pack_cmpl(cmpl_any_q, cmpl_idx_q);
  assign err_byte  = pack_err(err_kind_q, err_idx_q);

  info_read_mux u_rd (
    .rd_word(rd_word), .rd_addr(rd_addr),
    .cmpl_byte(cmpl_byte), .err_byte(err_byte), .rd_data(rd_data)
  );
endmodule

// File: rtl/msg_irq_info_chk.sv
module msg_irq_info_chk #(
  parameter int NUM_OBJ = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_OBJ-1:0] masked,
  input logic               cmpl_any_q,
  input logic [4:0]         cmpl_idx_q,
  input logic               err_evt,
  input logic [2:0]         err_kind_q,
  input logic [4:0]         err_idx_q,
  input logic               rd_word,
  input logic [15:0]        rd_data
);
  logic               past_valid;
  logic [NUM_OBJ-1:0] masked_d1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      past_valid <= 1'b0;
      masked_d1  <= '0;
    end else begin
      past_valid <= 1'b1;
      masked_d1  <= masked;
    end
  end

  // R1
  cmpl_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_valid |-> (cmpl_any_q == (|masked_d1)));

  // R2
  cmpl_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid && cmpl_any_q) |->
      (masked_d1[cmpl_idx_q] && ((masked_d1 & ((NUM_OBJ'(1) << cmpl_idx_q) - NUM_OBJ'(1))) == '0)));

  // R3
  cmpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmpl_any_q |-> (cmpl_idx_q == '0));

  // R5
  err_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(err_kind_q));

  // R6
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !err_evt |=> ($stable(err_kind_q) && $stable(err_idx_q)));

  // R10
  rd_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_word |-> (rd_data[15:8] == 8'h00));
endmodule

bind msg_irq_info msg_irq_info_chk #(.NUM_OBJ(NUM_OBJ)) u_chk (
  .clk(clk), .rst_n(rst_n), .masked(cmpl_masked),
  .cmpl_any_q(cmpl_any_q), .cmpl_idx_q(cmpl_idx_q),
  .err_evt(err_evt), .err_kind_q(err_kind_q), .err_idx_q(err_idx_q),
  .rd_word(rd_word), .rd_data(rd_data)
);

// File: tb/sim_msg_irq_info.sv
`timescale 1ns/1ps
module sim_msg_irq_info;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cmpl_flags = '0, irq_en = '0, ev_txund = '0, ev_frag = '0, ev_rxfull = '0;
  logic        rd_word = 1'b0, rd_addr = 1'b0;
  logic [15:0] rd_data;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  msg_irq_info u0 (
    .clk(clk), .rst_n(rst_n), .cmpl_flags(cmpl_flags), .irq_en(irq_en),
    .ev_txund(ev_txund), .ev_frag(ev_frag), .ev_rxfull(ev_rxfull),
    .rd_word(rd_word), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  typedef struct packed {
    logic [31:0] f;
    logic [31:0] e;
    logic [7:0]  exp;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{32'h0000_0000, 32'hFFFF_FFFF, 8'h00},
    '{32'hFFFF_FFFF, 32'h0000_0000, 8'h00},
    '{32'h0000_0001, 32'h0000_0001, 8'h20},
    '{32'h8000_0000, 32'h8000_0000, 8'h3F},
    '{32'h0000_F0F0, 32'h0000_0F00, 8'h00},
    '{32'hFFFF_0000, 32'h00FF_FF00, 8'h30},
    '{32'hAAAA_AAAA, 32'h5555_5555, 8'h00},
    '{32'h1234_5678, 32'hFFFF_FFF0, 8'h24}
  };

  function automatic logic [7:0] ref_cmpl(input logic [31:0] f, input logic [31:0] e);
    logic [31:0] m;
    m = f & e;
    for (int i = 0; i < 32; i++) if (m[i]) return 8'h20 | 8'(i);
    return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic w, input logic a, output logic [15:0] d);
    rd_word = w; rd_addr = a; #0.5; d = rd_data;
  endtask

  // Drive at a falling edge, let one rising edge pass, sample at the next falling edge.
  task automatic step();
    @(negedge clk);
  endtask

  task automatic err_ev(input logic [31:0] u, input logic [31:0] fr, input logic [31:0] fu);
    ev_txund = u; ev_frag = fr; ev_rxfull = fu;
    step();
    ev_txund = '0; ev_frag = '0; ev_rxfull = '0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [31:0] f, e;
    @(negedge clk); @(negedge clk);
    cmpl_flags = 32'hFFFF_FFFF; irq_en = 32'hFFFF_FFFF; ev_txund = 32'h1;
    step();
    rd(1'b1, 1'b0, d); chk("R9 reset word", d, 16'h0000);
    cmpl_flags = '0; irq_en = '0; ev_txund = '0;
    rst_n = 1'b1;
    step();
    rd(1'b1, 1'b0, d); chk("R9 after reset", d, 16'h0000);

    foreach (TBL[k]) begin
      cmpl_flags = TBL[k].f; irq_en = TBL[k].e;
      step();
      rd(1'b0, 1'b0, d);
      chk(TBL[k].exp == 8'h00 ? "R3 table" : "R1 R2 table", d, {8'h00, TBL[k].exp});
    end

    for (int n = 0; n < 300; n++) begin
      f = $urandom(); e = $urandom() & $urandom() & $urandom();
      if (n % 7 == 0) e = 32'h0;
      cmpl_flags = f; irq_en = e;
      step();
      rd(1'b0, 1'b0, d);
      chk("R2 random", d, {8'h00, ref_cmpl(f, e)});
      chk("R4 upper bits", {14'h0, d[7:6]}, 16'h0000);
    end

    err_ev(32'h0, 32'h0, 32'h0000_0080);
    rd(1'b0, 1'b1, d); chk("R5 rxfull obj7", d, 16'h0027);
    step(); step();
    rd(1'b0, 1'b1, d); chk("R6 hold", d, 16'h0027);
    err_ev(32'h0, 32'h8000_0000, 32'h0);
    rd(1'b0, 1'b1, d); chk("R5 frag obj31", d, 16'h005F);
    err_ev(32'h0000_0001, 32'h0, 32'h0);
    rd(1'b0, 1'b1, d); chk("R5 txund obj0", d, 16'h0080);
    err_ev(32'h0000_0200, 32'h0, 32'h0000_0008);
    rd(1'b0, 1'b1, d); chk("R7 lowest object", d, 16'h0023);
    err_ev(32'h0000_1000, 32'h0000_1000, 32'h0000_1000);
    rd(1'b0, 1'b1, d); chk("R8 underflow first", d, 16'h008C);
    err_ev(32'h0, 32'h0000_1000, 32'h0000_1000);
    rd(1'b0, 1'b1, d); chk("R8 frag over full", d, 16'h004C);

    cmpl_flags = 32'h0000_0020; irq_en = 32'h0000_0020;
    step();
    rd(1'b1, 1'b0, d); chk("R10 word", d, 16'h4C25);
    rd(1'b0, 1'b1, d); chk("R10 byte err", d, 16'h004C);
    rd(1'b0, 1'b0, d); chk("R10 byte cmpl", d, 16'h0025);

    rst_n = 1'b0;
    step();
    rd(1'b1, 1'b0, d); chk("R9 mid reset", d, 16'h0000);
    rst_n = 1'b1;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule